// File: doc/BRIEF.md
# PCI Function Power-State and Wake Controller

This block holds the power-management control/status register of a single PCI function. Software writes the register through a plain configuration write strobe to move the function between the full-power state D0 and the low-power states D2 and D3. While the function is not in D0, the block drops its interrupt-enable and BAR-access-enable outputs. The function's interrupt and its I/O and memory decode are switched off, and configuration accesses keep working.

Each multi-purpose input pin has an arm bit. Once a pin is armed, either a rising or a falling edge on it is a wake event. The pin is first passed through a synchronizer. A wake event latches a sticky status bit, but only while the PME enable bit is set. The status bit drives an active-low PME output. Software clears the bit by writing a one to it, and must bring the function back to D0 itself.

The block has two resets. The function reset returns the power state and the enable bit to their defaults. The status bit survives that reset and is cleared only by power-on reset.

Top module: `pci_pm_wake`

## Requirements
- R1: After power-on reset, the register reads 16'h0000. This means state D0 (bits [1:0] = 00), PME enable (bit 8) = 0 and PME status (bit 15) = 0. `irq_en` and `bar_en` are 1 and `pme_n` is 1.
- R2: A write with bits [1:0] = 10 selects D2 and a write with 11 selects D3. The new state reads back, and `irq_en` and `bar_en` are 0 from the cycle after the write.
- R3: A write with bits [1:0] = 01 (the unsupported D1) leaves the power state unchanged. The other fields of that write still take effect.
- R4: A write with bits [1:0] = 00 returns the function to D0 and sets `irq_en` and `bar_en` back to 1.
- R5: With bit 8 = 1, a rising or falling edge on an armed `mio_in` pin sets bit 15, and `pme_n` goes low within four clock cycles.
- R6: An edge on a pin whose arm bit is 0 never sets bit 15. Neither does any edge while bit 8 = 0.
- R7: Bit 15 is sticky. A write with bit 15 = 0 keeps it set. A write with bit 15 = 1 clears it, which returns `pme_n` to 1.
- R8: A function reset (`rst_n`) returns the state to D0 and bit 8 to 0 but keeps bit 15. Only `por_n` clears bit 15.
- R9: A pin that is already high when reset is released does not count as an edge.
- R10: A wake event never changes the power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active-low |
| rst_n | input | 1 | Function reset, asynchronous active-low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| mio_in | input | NUM_PINS | Multi-purpose input pins (asynchronous) |
| wake_arm | input | NUM_PINS | Per-pin wake arm bits |
| irq_en | output | 1 | Function interrupt allowed |
| bar_en | output | 1 | I/O and memory BAR decode allowed |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The bench uses the default parameters: two wake pins and a two-stage synchronizer. With two pins, it can arm one pin and toggle the other, which shows that arming is selective. The shallow synchronizer keeps the time from a pin edge to `pme_n` short and fixed, so the bench can check a wake result a few cycles after the edge. It can also check the power-up case where a pin is held high through reset.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  localparam int REG_W      = 16;
  localparam int BIT_PME_EN = 8;
  localparam int BIT_PME_ST = 15;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] arm_i,
  output logic                wake_o
);
  localparam int FILL   = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(FILL + 1);

  logic [NUM_PINS-1:0] level, prev_q, toggled;
  logic [CNT_W-1:0]    fill_q, fill_d;
  logic                primed;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      logic [SYNC_STAGES-1:0] sync_q, sync_d;
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_i[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
      end
      assign level[g] = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign primed = (fill_q == CNT_W'(FILL));

  always_comb begin
    fill_d = fill_q;
    if (!primed) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign toggled = level ^ prev_q;
  assign wake_o  = primed & (|(toggled & arm_i));

  // R6: an unarmed pin set cannot produce a wake
  assert_unarmed_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i == '0) |-> !wake_o);
endmodule

// File: rtl/pm_csr.sv
module pm_csr
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             fn_rst_n,
  input  logic             por_rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             wake_i,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             irq_en,
  output logic             bar_en,
  output logic             pme_n
);
  pstate_e state_q, state_d;
  logic    pme_en_q, pme_en_d;
  logic    pme_st_q, pme_st_d;
  logic    w1c;

  assign w1c = cfg_wr & cfg_wdata[BIT_PME_ST];

  always_comb begin
    state_d  = state_q;
    pme_en_d = pme_en_q;
    if (cfg_wr) begin
      pme_en_d = cfg_wdata[BIT_PME_EN];
      if (cfg_wdata[1:0] != PS_D1) state_d = pstate_e'(cfg_wdata[1:0]);
    end
  end

  // a wake in the same cycle as a clear wins, so no event is lost
  always_comb pme_st_d = (pme_st_q & ~w1c) | (pme_en_q & wake_i);

  always_ff @(posedge clk or negedge fn_rst_n) begin
    if (!fn_rst_n) begin
      state_q  <= PS_D0;
      pme_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pme_en_q <= pme_en_d;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) pme_st_q <= 1'b0;
    else            pme_st_q <= pme_st_d;
  end

  always_comb begin
    cfg_rdata             = '0;
    cfg_rdata[1:0]        = state_q;
    cfg_rdata[BIT_PME_EN] = pme_en_q;
    cfg_rdata[BIT_PME_ST] = pme_st_q;
  end

  assign irq_en = (state_q == PS_D0);
  assign bar_en = (state_q == PS_D0);
  assign pme_n  = ~pme_st_q;

  assert_lowpwr_gates_R2: assert property (@(posedge clk) disable iff (!fn_rst_n)
    (cfg_wr && cfg_wdata[1]) |=> (!bar_en && !irq_en));

  assert_d1_ignored_R3: assert property (@(posedge clk) disable iff (!fn_rst_n)
    (cfg_wr && cfg_wdata[1:0] == 2'b01) |=> $stable(cfg_rdata[1:0]));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!por_rst_n || !fn_rst_n)
    (!pme_n && !(cfg_wr && cfg_wdata[BIT_PME_ST])) |=> !pme_n);

  assert_no_set_disabled_R6: assert property (@(posedge clk) disable iff (!por_rst_n || !fn_rst_n)
    (pme_n && !cfg_rdata[BIT_PME_EN]) |=> pme_n);

  assert_wake_keeps_state_R10: assert property (@(posedge clk) disable iff (!fn_rst_n)
    !cfg_wr |=> $stable(cfg_rdata[1:0]));
endmodule

// File: rtl/pci_pm_wake.sv
module pci_pm_wake
  import pm_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic [NUM_PINS-1:0] mio_in,
  input  logic [NUM_PINS-1:0] wake_arm,
  output logic                irq_en,
  output logic                bar_en,
  output logic                pme_n
);
  logic por_s_n, fn_s_n, wake;

  pm_rst_sync #(.STAGES(2)) u_por_sync (.clk(clk), .arst_n(por_n), .srst_n(por_s_n));
  pm_rst_sync #(.STAGES(2)) u_fn_sync  (.clk(clk), .arst_n(rst_n & por_n), .srst_n(fn_s_n));

  pm_wake_detect #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst_n(fn_s_n), .pin_i(mio_in), .arm_i(wake_arm), .wake_o(wake)
  );

  pm_csr u_csr (
    .clk(clk), .fn_rst_n(fn_s_n), .por_rst_n(por_s_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wake_i(wake),
    .cfg_rdata(cfg_rdata), .irq_en(irq_en), .bar_en(bar_en), .pme_n(pme_n)
  );
endmodule

// File: tb/pci_pm_wake_test.sv
module pci_pm_wake_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic clk = 0, por_n = 0, rst_n = 0, cfg_wr = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic [NP-1:0] mio_in = '0, wake_arm = '0;
  logic irq_en, bar_en, pme_n;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_pm_wake #(.NUM_PINS(NP), .SYNC_STAGES(2)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mio_in(mio_in), .wake_arm(wake_arm),
    .irq_en(irq_en), .bar_en(bar_en), .pme_n(pme_n)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); cfg_wr = 1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic t_reset_R1;
    por_n = 0; rst_n = 0; idle(2); por_n = 1; rst_n = 1; idle(6);
    chk("R1 rdata", cfg_rdata, 16'h0000);
    chk("R1 enables", {14'b0, irq_en, bar_en}, 16'h3);
    chk("R1 pme_n", {15'b0, pme_n}, 16'h1);
  endtask

  task automatic t_states_R2_R3_R4;
    wr(16'h0002);
    chk("R2 D2 read", cfg_rdata, 16'h0002);
    chk("R2 D2 gates", {14'b0, irq_en, bar_en}, 16'h0);
    wr(16'h0003);
    chk("R2 D3 read", cfg_rdata, 16'h0003);
    chk("R2 D3 gates", {14'b0, irq_en, bar_en}, 16'h0);
    wr(16'h0101);
    chk("R3 D1 ignored, enable taken", cfg_rdata, 16'h0103);
    wr(16'h0000);
    chk("R4 D0 read", cfg_rdata, 16'h0000);
    chk("R4 enables back", {14'b0, irq_en, bar_en}, 16'h3);
    wr(16'h0001);
    chk("R3 D1 from D0", cfg_rdata, 16'h0000);
  endtask

  task automatic t_wake_R5_R7_R10;
    wr(16'h0103); wake_arm = 2'b01;
    @(negedge clk); mio_in[0] = 1; idle(4);
    chk("R5 rise sets status", cfg_rdata, 16'h8103);
    chk("R5 pme_n low", {15'b0, pme_n}, 16'h0);
    chk("R10 state kept", {14'b0, cfg_rdata[1:0]}, 16'h3);
    wr(16'h0100);
    chk("R7 write 0 keeps", cfg_rdata, 16'h8100);
    wr(16'h8100);
    chk("R7 w1c clears", cfg_rdata, 16'h0100);
    chk("R7 pme_n high", {15'b0, pme_n}, 16'h1);
    @(negedge clk); mio_in[0] = 0; idle(4);
    chk("R5 fall sets status", cfg_rdata[15:0], 16'h8100);
    wr(16'h8100);
  endtask

  task automatic t_nowake_R6;
    wake_arm = 2'b01;
    @(negedge clk); mio_in[1] = 1; idle(6);
    chk("R6 unarmed pin", cfg_rdata, 16'h0100);
    wr(16'h0000);
    @(negedge clk); mio_in[0] = 1; idle(6);
    chk("R6 enable off", cfg_rdata, 16'h0000);
    chk("R6 pme_n", {15'b0, pme_n}, 16'h1);
  endtask

  task automatic t_resets_R8;
    wr(16'h0102);
    @(negedge clk); mio_in[0] = 0; idle(5);
    chk("R8 status set", cfg_rdata, 16'h8102);
    @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(5);
    chk("R8 fn reset keeps status", cfg_rdata, 16'h8000);
    @(negedge clk); por_n = 0; idle(2); por_n = 1; idle(5);
    chk("R8 por clears", cfg_rdata, 16'h0000);
  endtask

  task automatic t_powerup_R9;
    wake_arm = 2'b11; mio_in = 2'b11;
    @(negedge clk); por_n = 0; rst_n = 0; idle(2);
    wr(16'h0000);
    por_n = 1; rst_n = 1;
    @(negedge clk); cfg_wr = 1; cfg_wdata = 16'h0100;
    @(negedge clk); cfg_wdata = 16'h0100;
    repeat (6) @(negedge clk);
    cfg_wr = 0; cfg_wdata = '0; idle(4);
    chk("R9 no spurious edge", cfg_rdata, 16'h0100);
    chk("R9 pme_n", {15'b0, pme_n}, 16'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_R1;
    t_states_R2_R3_R4;
    t_wake_R5_R7_R10;
    t_nowake_R6;
    t_resets_R8;
    t_powerup_R9;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule